// File: doc/BRIEF.md
# Double-Length Accumulator Shift Unit

This block holds a 64-bit quantity split across two 32-bit registers: the accumulator A forms the upper half and the register R the lower half. On a start request it shifts the pair right by one bit in each clock cycle. Each clock cycle stands for one word time.

The shift has two modes. In rotate mode the bits that leave the bottom of the pair re-enter at the top. In arithmetic mode the pair is treated as a signed 64-bit value, and the sign bit of A is copied downward.

The shift length comes from a 6-bit step field. The field counts up by one on each step, and the run ends when the field wraps to zero. A field value c therefore gives 64 − c steps, and a field of zero gives no shift at all. Software or a sequencer first loads A and R in parallel. It then pulses start and waits for the one-cycle done pulse, after which the result stays on the outputs.

Top module: `dlshift_unit`

## Requirements
- R1: After a synchronous reset, a_out and r_out are zero and done is low.
- R2: When no run is active, a cycle with load high writes a_in into A and r_in into R, and the new values appear on the outputs after that clock edge.
- R3: Rotate mode (mode = 0) moves the 64-bit pair {A,R} one place to the right per step. Bit 0 of R goes to bit 31 of A, and bit 0 of A goes to bit 31 of R.
- R4: Arithmetic mode (mode = 1) moves {A,R} one place to the right per step while bit 31 of A keeps its value. Bit 0 of A goes to bit 31 of R, and bit 0 of R is lost.
- R5: A start accepted with a nonzero count_in c performs exactly 64 − c steps, one per clock. done is high in the cycle that follows the clock edge of the last step, and the outputs then show the final result.
- R6: A start accepted with count_in = 0 changes neither A nor R, and done is high in the cycle directly after the start edge.
- R7: done stays high for exactly one cycle.
- R8: When no run is active and load is low, A and R keep their values; this includes the cycles after done.
- R9: While a run is active, start and load are ignored. The step count, the done timing and the result are unchanged by them.
- R10: The mode is captured when start is accepted, so a change on mode during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a shift run (accepted only when idle) |
| mode | input | 1 | 0 = rotate, 1 = arithmetic |
| count_in | input | 6 | Initial step field; steps = 64 − value, 0 = none |
| load | input | 1 | Parallel load of A and R (accepted only when idle) |
| a_in | input | 32 | Value loaded into A |
| r_in | input | 32 | Value loaded into R |
| a_out | output | 32 | Accumulator A (upper half) |
| r_out | output | 32 | Register R (lower half) |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench aims at the ends of the count range: a field of 0, which must give no shift and an immediate done, and a field of 1, which must give 63 steps. A unit that counted down, or that stopped one step early or late, would raise done in the wrong cycle and leave the pair off by a bit.

Arithmetic runs on negative accumulators expose a unit that fills with zeros instead of the sign. Rotate runs expose a unit that drops bit 0 of R instead of feeding it back into A.

Some runs are disturbed partway through with start, load and a flipped mode. A unit that reloads its registers, restarts its count or follows the live mode input would then give a different result or a different done cycle.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic {
    SH_ROTATE = 1'b0,
    SH_ARITH  = 1'b1
  } shmode_e;
endpackage

// File: rtl/dls_step.sv
// One right-shift step of the double-length pair; purely combinational.
module dls_step
  import dls_pkg::*;
#(
  parameter int W = 32
) (
  input  shmode_e        mode,
  input  logic [W-1:0]   a_cur,
  input  logic [W-1:0]   r_cur,
  output logic [W-1:0]   a_nxt,
  output logic [W-1:0]   r_nxt
);
  logic top_fill;

  always_comb begin
    top_fill = (mode == SH_ARITH) ? a_cur[W-1] : r_cur[0];
    a_nxt    = {top_fill, a_cur[W-1:1]};
    r_nxt    = {a_cur[0], r_cur[W-1:1]};
  end
endmodule

// File: rtl/dls_seq.sv
// Run control: step field counting up to its wrap, busy flag, done pulse.
module dls_seq
  import dls_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  shmode_e          mode,
  input  logic [CNT_W-1:0] count_in,
  output logic             busy,
  output shmode_e          mode_q,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      mode_q <= SH_ROTATE;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          mode_q <= mode;
          cnt    <= count_in;
          if (count_in == '0) done <= 1'b1;
          else                busy <= 1'b1;
        end
      end else begin
        cnt <= cnt_inc;
        if (cnt_inc == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && count_in == '0) |=> (done && !busy)); // R6
  AST_RUN_END: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == CNT_LAST) |=> (done && !busy)); // R5
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CNT_LAST) |=> (!done && busy)); // R9
endmodule

// File: rtl/dls_regs.sv
// A and R storage: shift has priority, parallel load only when idle.
module dls_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] r_in,
  input  logic [W-1:0] a_nxt,
  input  logic [W-1:0] r_nxt,
  output logic [W-1:0] a_q,
  output logic [W-1:0] r_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      r_q <= '0;
    end else if (step_en) begin
      a_q <= a_nxt;
      r_q <= r_nxt;
    end else if (load) begin
      a_q <= a_in;
      r_q <= r_in;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load) |=> ($stable(a_q) && $stable(r_q))); // R8
endmodule

// File: rtl/dlshift_unit.sv
module dlshift_unit
  import dls_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [CNT_W-1:0] count_in,
  input  logic             load,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     r_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     r_out,
  output logic             done
);
  logic         busy;
  shmode_e      mode_q;
  logic [W-1:0] a_nxt, r_nxt;

  dls_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(shmode_e'(mode)),
    .count_in(count_in), .busy(busy), .mode_q(mode_q), .done(done)
  );

  dls_step #(.W(W)) u_step (
    .mode(mode_q), .a_cur(a_out), .r_cur(r_out), .a_nxt(a_nxt), .r_nxt(r_nxt)
  );

  dls_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .step_en(busy), .load(load),
    .a_in(a_in), .r_in(r_in), .a_nxt(a_nxt), .r_nxt(r_nxt),
    .a_q(a_out), .r_q(r_out)
  );

  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == SH_ROTATE) |=>
      ($countones({a_out, r_out}) == $past($countones({a_out, r_out})))); // R3
  AST_ARI_SIGN: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == SH_ARITH) |=> $stable(a_out[W-1])); // R4
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (busy && load) |=> (r_out[W-2:0] == $past(r_out[W-1:1]))); // R9
endmodule

// File: tb/tb_dlshift_unit.sv
`timescale 1ns/1ps
module tb_dlshift_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, mode, load;
  logic [5:0]  count_in;
  logic [31:0] a_in, r_in;
  logic [31:0] a_out, r_out;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dlshift_unit dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .count_in(count_in),
    .load(load), .a_in(a_in), .r_in(r_in), .a_out(a_out), .r_out(r_out),
    .done(done)
  );

  function automatic logic [63:0] model(input logic [63:0] v, input logic m, input int n);
    logic [63:0] x = v;
    for (int i = 0; i < n; i++)
      x = m ? {x[63], x[63:1]} : {x[0], x[63:1]};
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%016h expected=%016h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // R3 R4 R5 R6 R7 R8 R9 R10: one run, optionally disturbed mid-way
  task automatic run(input logic [31:0] a, input logic [31:0] r, input logic m,
                     input logic [5:0] c, input bit disturb);
    int n, k, bad;
    logic [63:0] exp;
    @(negedge clk);
    load = 1; a_in = a; r_in = r; start = 1; mode = m; count_in = c;
    @(negedge clk);
    load = 0; start = 0;
    n = (c == 0) ? 0 : 64 - int'(c);
    k = 0; bad = 0;
    while (1) begin
      if (disturb && n > 4) begin
        if (k == 2) begin
          load = 1; a_in = ~a; r_in = ~r; start = 1; count_in = c + 6'd5; mode = ~m;
        end else if (k == 3) begin
          load = 0; start = 0;
        end
      end
      if (done !== (k == n)) bad++;
      if (k >= n) break;
      @(negedge clk);
      k++;
    end
    exp = model({a, r}, m, n);
    check(bad == 0, (c == 0) ? "R6 done timing" : "R5 done timing", 64'(bad), 64'd0);
    check({a_out, r_out} === exp, m ? "R4 arith result (R9 R10)" : "R3 rotate result (R9 R10)",
          {a_out, r_out}, exp);
    @(negedge clk);
    check(done === 1'b0 && {a_out, r_out} === exp, "R7 R8 pulse end and hold",
          {63'd0, done} ^ {a_out, r_out}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] ra, rr;
    logic [5:0]  rc;
    logic        rm;
    void'($urandom(32'h5EED1234));
    rst = 1; start = 0; mode = 0; load = 0; count_in = 0; a_in = 0; r_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(a_out === 0 && r_out === 0 && done === 0, "R1 reset state", {a_out, r_out}, 64'd0);

    // R2 load, then R8 hold while idle
    load = 1; a_in = 32'hDEADBEEF; r_in = 32'h01234567;
    @(negedge clk);
    load = 0;
    check({a_out, r_out} === 64'hDEADBEEF_01234567, "R2 parallel load", {a_out, r_out}, 64'hDEADBEEF_01234567);
    repeat (3) @(negedge clk);
    check({a_out, r_out} === 64'hDEADBEEF_01234567 && done === 0, "R8 idle hold",
          {a_out, r_out}, 64'hDEADBEEF_01234567);

    // directed corners
    run(32'h80000001, 32'h00000003, 1'b0, 6'd0,  1'b0); // R6
    run(32'h80000001, 32'h00000003, 1'b0, 6'd63, 1'b0); // R3 single step
    run(32'h80000000, 32'h00000001, 1'b1, 6'd63, 1'b0); // R4 single step, sign
    run(32'hF0000000, 32'h0000000F, 1'b1, 6'd1,  1'b0); // R4 63 steps negative
    run(32'h12345678, 32'h9ABCDEF0, 1'b0, 6'd1,  1'b0); // R3 63 steps
    run(32'hA5A5A5A5, 32'h3C3C3C3C, 1'b1, 6'd32, 1'b1); // R9 R10 disturbed
    run(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 6'd40, 1'b1); // R9 R10 disturbed

    for (int i = 0; i < 40; i++) begin
      ra = $urandom; rr = $urandom; rm = 1'($urandom); rc = 6'($urandom);
      run(ra, rr, rm, rc, (i % 3) == 0);
    end
    report();
  end
endmodule